// File: doc/BRIEF.md
# Parallel Program-Load Cycle Controller

This block decodes byte-wide programming cycles for an embedded nonvolatile program/data store while the device is held in its load state. The load-reset pin must be high for any cycle. Each clock the block samples six things: the program-store enable, the program strobe, a flag from an external detector that says the programming voltage is present, and three select bits. From these it works out which cycle is wanted: program, verify, security-set, expanded program, expanded verify or control/key register write. It then runs that cycle on a simple write/read port to the memory array.

A cycle starts when the decoded cycle type changes to something other than idle. A type that is held produces one cycle only. Normal cycles reach the lowest 4 KB. Expanded cycles reach the full 32 KB and spend eight extra clocks busy before they touch the array. The block holds a control byte with three fields: a security lock, a memory-range selector and a code/data partition. It also holds five encryption key bytes. Control and key registers are written through the same cycle path as memory. The first program or security-set cycle after power-on applies a default 8 KB map with a 4 KB code area.

Top module: `pload_ctrl`

## Requirements
- R1: After reset, busy, write strobe, read strobe, read-valid and mode error are low. The control byte is 0xF8 and all key bytes are 0x00.
- R2: A program cycle needs load reset 1, program-store enable 0, strobe 0, voltage 1 and select 3'b10x. It raises the write strobe for exactly one clock, the cycle after the sampling edge. The address is cut to its low 12 bits and the data byte goes out unchanged.
- R3: A verify cycle needs voltage 0 and select 3'b00x. It raises the read strobe for one clock, the cycle after the sampling edge. One clock later read-valid is high for one clock, with the array byte on the read-data output.
- R4: Select 3'b010 gives expanded cycles. With voltage 1 and the strobe low, it is a program cycle. With voltage 0, program-store enable 0 and the strobe high, it is a verify cycle. Busy stays high for 8 clocks and then for one access clock, using the full 15-bit address.
- R5: A security-set cycle needs the program-cycle pins with select 3'b11x. It sets control bit 0, the lock, and writes nothing to memory. Once set, the lock stays set until a control-register write clears it.
- R6: Only the first program or security-set cycle after reset clears control bit 3 (range, 0 = 8 KB) and sets control bits 7:4 (partition, in 2 KB units) to 2. Later program cycles leave the control byte unchanged.
- R7: A register cycle needs the program-cycle pins with select 3'b011 and address bits 14:8 at zero. Low address 0x10 writes the control byte. Low addresses 0x11 to 0x15 write key bytes 0 to 4, and key byte k appears at key output bits 8k+7:8k. No memory write happens.
- R8: While the lock is set, every verify cycle returns 0xFF.
- R9: Some inputs are undefined: the strobe low with voltage 1 and select 3'b00x; the strobe low with voltage 0 and any other select; a register cycle at any other address. Each of these raises mode error for one clock and does no access. The control byte is unchanged.
- R10: While load reset is 0, no cycle starts, whatever the other pins do.
- R11: Holding the same cycle pins for many clocks produces a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_rst_i | input | 1 | Load-mode reset pin, high to allow cycles |
| pse_n_i | input | 1 | Program-store enable, active low |
| stb_n_i | input | 1 | Program strobe, active low |
| hv_ok_i | input | 1 | Programming voltage present |
| sel_i | input | 3 | Cycle select bits (high port bits 7..5) |
| addr_i | input | 15 | Cycle address |
| wdata_i | input | 8 | Cycle data |
| mem_we_o | output | 1 | Array write strobe |
| mem_re_o | output | 1 | Array read strobe |
| mem_addr_o | output | 15 | Array address |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, same cycle as read strobe |
| rdata_o | output | 8 | Verify result |
| rd_valid_o | output | 1 | Verify result valid, one clock |
| busy_o | output | 1 | Cycle in progress |
| mode_err_o | output | 1 | Undefined combination seen, one clock |
| ctrl_o | output | 8 | Control byte (lock, range, partition) |
| key_o | output | 40 | Five key bytes |

## Verification
The first-strobe default map and a security-set lock can both update the control byte in one clock. To provoke this, the bench makes a security-set cycle the very first cycle after reset. It then expects 0x21: partition 2, range 0 and lock 1, with no field lost. A second overlap comes from an expanded verify on a locked device, where the lock substitution has to win over the array data. The bench also sweeps all 128 pin combinations and counts strobes, busy clocks and error pulses against a classification made from the requirements.

// File: rtl/pload_pkg.sv
package pload_pkg;
  typedef enum logic [2:0] {
    K_IDLE, K_PROG, K_SEC, K_VER, K_XPROG, K_XVER, K_CREG, K_ERR
  } kind_e;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACT} st_e;

  localparam logic [7:0] CTRL_RST  = 8'hF8;
  localparam int         LOCK_BIT  = 0;
  localparam int         RANGE_BIT = 3;
  localparam int         PART_LSB  = 4;
  localparam logic [3:0] PART_DFLT = 4'd2;
endpackage

// File: rtl/pload_decode.sv
module pload_decode
  import pload_pkg::*;
(
  input  logic       ld_i,
  input  logic       pse_n_i,
  input  logic       stb_n_i,
  input  logic       hv_i,
  input  logic [2:0] sel_i,
  output kind_e      kind_o
);
  logic pgm;
  assign pgm = !pse_n_i && !stb_n_i;

  always_comb begin
    kind_o = K_IDLE;
    if (ld_i) begin
      if (hv_i) begin
        if (pgm) begin
          if (sel_i[2])          kind_o = sel_i[1] ? K_SEC : K_PROG;
          else if (sel_i[1])     kind_o = sel_i[0] ? K_CREG : K_XPROG;
          else                   kind_o = K_ERR;
        end
      end else begin
        if (sel_i[2:1] == 2'b00)                   kind_o = K_VER;
        else if (!stb_n_i)                         kind_o = K_ERR;
        else if (sel_i == 3'b010 && !pse_n_i)      kind_o = K_XVER;
      end
    end
  end
endmodule

// File: rtl/pload_seq.sv
module pload_seq
  import pload_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int NRM_W    = 12,
  parameter int XTRA     = 8,
  parameter int NKEY     = 5,
  parameter int CTRL_ADR = 16,
  parameter int DW       = 8,
  localparam int IDX_W   = $clog2(NKEY + 1),
  localparam int CNT_W   = $clog2(XTRA + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              lock_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              reg_we_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              prog_evt_o,
  output logic              sec_evt_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              mode_err_o
);
  st_e               st_q, st_n;
  kind_e             kind_q, op_q;
  logic [ADDR_W-1:0] adr_q, adr_n;
  logic [DW-1:0]     dat_q, rdat_q, rdat_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              rv_q, err_q;
  logic              launch, creg_ok, bad, go, xp, act, rd_en;
  logic [7:0]        lo;

  assign lo      = addr_i[7:0];
  assign creg_ok = (addr_i[ADDR_W-1:8] == '0) && (int'(lo) >= CTRL_ADR)
                   && (int'(lo) <= CTRL_ADR + NKEY);
  assign launch  = (st_q == S_IDLE) && (kind_i != kind_q) && (kind_i != K_IDLE);
  assign bad     = launch && (kind_i == K_ERR || (kind_i == K_CREG && !creg_ok));
  assign go      = launch && !bad;
  assign xp      = (kind_i == K_XPROG) || (kind_i == K_XVER);
  assign adr_n   = xp ? addr_i : ADDR_W'(addr_i[NRM_W-1:0]);
  assign act     = (st_q == S_ACT);
  assign rd_en   = act && (op_q == K_VER || op_q == K_XVER);
  assign rdat_n  = lock_i ? {DW{1'b1}} : mem_rdata_i;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    case (st_q)
      S_IDLE: if (go) begin
        st_n  = xp ? S_WAIT : S_ACT;
        cnt_n = '0;
      end
      S_WAIT: if (cnt_q == CNT_W'(XTRA - 1)) st_n = S_ACT;
              else                           cnt_n = cnt_q + 1'b1;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= K_IDLE;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_i;
      cnt_q  <= cnt_n;
      err_q  <= bad;
      rv_q   <= rd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= K_IDLE;
      adr_q <= '0;
      dat_q <= '0;
    end else if (go) begin
      op_q  <= kind_i;
      adr_q <= adr_n;
      dat_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdat_q <= '0;
    else if (rd_en)  rdat_q <= rdat_n;
  end

  assign mem_we_o    = act && (op_q == K_PROG || op_q == K_XPROG);
  assign mem_re_o    = rd_en;
  assign mem_addr_o  = adr_q;
  assign mem_wdata_o = dat_q;
  assign reg_we_o    = act && (op_q == K_CREG);
  assign reg_idx_o   = IDX_W'(adr_q[7:0] - 8'(CTRL_ADR));
  assign prog_evt_o  = act && (op_q == K_PROG || op_q == K_SEC);
  assign sec_evt_o   = act && (op_q == K_SEC);
  assign rdata_o     = rdat_q;
  assign rd_valid_o  = rv_q;
  assign busy_o      = (st_q != S_IDLE);
  assign mode_err_o  = err_q;
endmodule

// File: rtl/pload_cfg.sv
module pload_cfg
  import pload_pkg::*;
#(
  parameter int NKEY = 5,
  parameter int DW   = 8,
  localparam int IDX_W = $clog2(NKEY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_evt_i,
  input  logic              sec_evt_i,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [7:0]        ctrl_o,
  output logic [NKEY*DW-1:0] key_o,
  output logic              lock_o
);
  logic [7:0] ctrl_q, ctrl_n;
  logic       mapped_q, map_now, ctrl_wr, ctrl_en;

  assign map_now = prog_evt_i && !mapped_q;
  assign ctrl_wr = reg_we_i && (reg_idx_i == '0);
  assign ctrl_en = map_now || sec_evt_i || ctrl_wr;

  always_comb begin
    ctrl_n = ctrl_q;
    if (map_now) begin
      ctrl_n[RANGE_BIT]           = 1'b0;
      ctrl_n[PART_LSB +: 4]       = PART_DFLT;
    end
    if (sec_evt_i) ctrl_n[LOCK_BIT] = 1'b1;
    if (ctrl_wr)   ctrl_n = wdata_i[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_en) ctrl_q <= ctrl_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mapped_q <= 1'b0;
    else if (map_now) mapped_q <= 1'b1;
  end

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    logic          en;
    logic [DW-1:0] q;
    assign en = reg_we_i && (reg_idx_i == IDX_W'(k + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata_i;
    end
    assign key_o[k*DW +: DW] = q;
  end

  assign ctrl_o = ctrl_q;
  assign lock_o = ctrl_q[LOCK_BIT];
endmodule

// File: rtl/pload_ctrl.sv
module pload_ctrl
  import pload_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int NRM_W    = 12,
  parameter int XTRA     = 8,
  parameter int NKEY     = 5,
  parameter int CTRL_ADR = 16,
  parameter int DW       = 8,
  localparam int IDX_W   = $clog2(NKEY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_rst_i,
  input  logic               pse_n_i,
  input  logic               stb_n_i,
  input  logic               hv_ok_i,
  input  logic [2:0]         sel_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               rd_valid_o,
  output logic               busy_o,
  output logic               mode_err_o,
  output logic [7:0]         ctrl_o,
  output logic [NKEY*DW-1:0] key_o
);
  kind_e             kind;
  logic              lock, reg_we, prog_evt, sec_evt;
  logic [IDX_W-1:0]  reg_idx;

  pload_decode u_dec (
    .ld_i(ld_rst_i), .pse_n_i(pse_n_i), .stb_n_i(stb_n_i),
    .hv_i(hv_ok_i), .sel_i(sel_i), .kind_o(kind)
  );

  pload_seq #(
    .ADDR_W(ADDR_W), .NRM_W(NRM_W), .XTRA(XTRA), .NKEY(NKEY),
    .CTRL_ADR(CTRL_ADR), .DW(DW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .kind_i(kind), .addr_i(addr_i),
    .wdata_i(wdata_i), .lock_i(lock), .mem_rdata_i(mem_rdata_i),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .reg_we_o(reg_we), .reg_idx_o(reg_idx),
    .prog_evt_o(prog_evt), .sec_evt_o(sec_evt), .rdata_o(rdata_o),
    .rd_valid_o(rd_valid_o), .busy_o(busy_o), .mode_err_o(mode_err_o)
  );

  pload_cfg #(.NKEY(NKEY), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .prog_evt_i(prog_evt), .sec_evt_i(sec_evt),
    .reg_we_i(reg_we), .reg_idx_i(reg_idx), .wdata_i(mem_wdata_o),
    .ctrl_o(ctrl_o), .key_o(key_o), .lock_o(lock)
  );
endmodule

// File: rtl/pload_chk.sv
module pload_chk #(
  parameter int ADDR_W = 15,
  parameter int NRM_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              mode_err,
  input logic              rd_valid,
  input logic [7:0]        rdata,
  input logic              lock,
  input logic              reg_we
);
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));                                              // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));                                   // R4
  AST_NORMAL_4K: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && $past(!busy) |-> mem_addr[ADDR_W-1:NRM_W] == '0); // R2
  AST_RV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_re));                                       // R3
  AST_LOCKED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(lock) |-> rdata == 8'hFF);                       // R8
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) && !$past(reg_we) |-> lock);                           // R5
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (!busy && !mem_we && !mem_re));                       // R9
endmodule

bind pload_ctrl pload_chk #(.ADDR_W(ADDR_W), .NRM_W(NRM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we_o), .mem_re(mem_re_o),
  .mem_addr(mem_addr_o), .busy(busy_o), .mode_err(mode_err_o),
  .rd_valid(rd_valid_o), .rdata(rdata_o), .lock(lock), .reg_we(reg_we)
);

// File: tb/sim_pload_ctrl.sv
module sim_pload_ctrl;
  localparam int KI = 0, KP = 1, KS = 2, KV = 3, KXP = 4, KXV = 5, KC = 6, KE = 7;

  logic        clk = 1'b0;
  logic        rst_n, ld, pse_n, stb_n, hv;
  logic [2:0]  sel;
  logic [14:0] addr;
  logic [7:0]  wdata;
  logic        mem_we, mem_re, rd_valid, busy, mode_err;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, rdata, ctrl;
  logic [39:0] key;
  logic [7:0]  mem [0:32767];
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pload_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ld_rst_i(ld), .pse_n_i(pse_n), .stb_n_i(stb_n),
    .hv_ok_i(hv), .sel_i(sel), .addr_i(addr), .wdata_i(wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .rdata_o(rdata),
    .rd_valid_o(rd_valid), .busy_o(busy), .mode_err_o(mode_err),
    .ctrl_o(ctrl), .key_o(key)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  function automatic logic [7:0] seed(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic drive(input logic l, p, s, h, input logic [2:0] se,
                       input logic [14:0] a, input logic [7:0] d);
    ld = l; pse_n = p; stb_n = s; hv = h; sel = se; addr = a; wdata = d;
  endtask

  task automatic neutral();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 15'h0, 8'h0);
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    neutral();
    rst_n = 1'b0;
    nclk(3);
    rst_n = 1'b1;
    nclk(1);
  endtask

  // one complete single-clock cycle from neutral, returns at the negedge after it
  task automatic run(input logic p, s, h, input logic [2:0] se,
                     input logic [14:0] a, input logic [7:0] d, input int len);
    neutral(); nclk(1);
    drive(1'b1, p, s, h, se, a, d);
    nclk(len);
    neutral();
  endtask

  function automatic int exp_kind(input logic l, p, s, h, input logic [2:0] se);
    if (!l) return KI;
    if (h) begin
      if (p || s) return KI;
      if (se[2]) return se[1] ? KS : KP;
      if (se[1]) return se[0] ? KC : KXP;
      return KE;
    end
    if (se[2:1] == 2'b00) return KV;
    if (!s) return KE;
    if (se == 3'b010 && !p) return KXV;
    return KI;
  endfunction

  initial begin
    for (int i = 0; i < 32768; i++) mem[i] = seed(i);
    do_reset();

    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 mem_re", mem_re, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 mode_err", mode_err, 0);
    chk("R1 ctrl", ctrl, 8'hF8);
    chk("R1 key", key, 40'h0);

    // Collision: security-set as first cycle, default map and lock together (R5, R6)
    run(1'b0, 1'b0, 1'b1, 3'b110, 15'h0123, 8'h77, 1);
    chk("R5 sec busy", busy, 1);
    chk("R5 sec no write", mem_we, 0);
    nclk(1);
    chk("R6 R5 first map with lock", ctrl, 8'h21);
    chk("R5 mem untouched", mem[15'h0123], seed(15'h0123));

    // Sweep every pin combination (R2 R3 R4 R5 R7 R9 R10)
    do_reset();
    for (int c = 0; c < 128; c++) begin
      int k, nwe, nre, nrv, nerr, nbusy, ewe, ere, eerr, ebusy;
      string tg;
      neutral(); nclk(2);
      drive(c[6], c[5], c[4], c[3], c[2:0], 15'h0010, 8'hF8);
      nwe = 0; nre = 0; nrv = 0; nerr = 0; nbusy = 0;
      for (int i = 0; i < 14; i++) begin
        @(negedge clk);
        nwe += int'(mem_we); nre += int'(mem_re); nrv += int'(rd_valid);
        nerr += int'(mode_err); nbusy += int'(busy);
      end
      k = exp_kind(c[6], c[5], c[4], c[3], c[2:0]);
      ewe   = (k == KP || k == KXP) ? 1 : 0;
      ere   = (k == KV || k == KXV) ? 1 : 0;
      eerr  = (k == KE) ? 1 : 0;
      ebusy = (k == KXP || k == KXV) ? 9 : (k == KI || k == KE) ? 0 : 1;
      case (k)
        KP: tg = "R2"; KV: tg = "R3"; KXP, KXV: tg = "R4"; KS: tg = "R5";
        KC: tg = "R7"; KE: tg = "R9"; default: tg = c[6] ? "R9 idle" : "R10";
      endcase
      chk($sformatf("%s sweep c=%0d writes", tg, c), nwe, ewe);
      chk($sformatf("%s sweep c=%0d reads", tg, c), nre, ere);
      chk($sformatf("%s sweep c=%0d valid", tg, c), nrv, ere);
      chk($sformatf("%s sweep c=%0d errors", tg, c), nerr, eerr);
      chk($sformatf("%s sweep c=%0d busy", tg, c), nbusy, ebusy);
    end

    // Directed program with address masking (R2, R6)
    do_reset();
    run(1'b0, 1'b0, 1'b1, 3'b100, 15'h7ABC, 8'h5A, 0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 3'b100, 15'h7ABC, 8'h5A);
    nclk(1);
    chk("R2 we", mem_we, 1);
    chk("R2 addr masked", mem_addr, 15'h0ABC);
    chk("R2 data", mem_wdata, 8'h5A);
    chk("R2 busy", busy, 1);
    begin
      int extra = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); extra += int'(mem_we); end
      chk("R11 held pins single write", extra, 0);
    end
    chk("R2 busy after", busy, 0);
    chk("R2 mem written", mem[15'h0ABC], 8'h5A);
    chk("R2 high bits ignored", mem[15'h7ABC], seed(15'h7ABC));
    chk("R6 default map", ctrl, 8'h20);

    // Verify (R3)
    run(1'b1, 1'b1, 1'b0, 3'b000, 15'h0ABC, 8'h00, 1);
    chk("R3 re", mem_re, 1);
    chk("R3 addr", mem_addr, 15'h0ABC);
    nclk(1);
    chk("R3 valid", rd_valid, 1);
    chk("R3 rdata", rdata, 8'h5A);
    nclk(1);
    chk("R3 valid one clock", rd_valid, 0);

    // Expanded program (R4)
    run(1'b0, 1'b0, 1'b1, 3'b010, 15'h5123, 8'h3C, 0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 3'b010, 15'h5123, 8'h3C);
    begin
      int wb = 0, we8 = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); wb += int'(busy); we8 += int'(mem_we); end
      chk("R4 wait busy", wb, 8);
      chk("R4 no early write", we8, 0);
    end
    nclk(1);
    chk("R4 write at ninth", mem_we, 1);
    chk("R4 full addr", mem_addr, 15'h5123);
    nclk(1);
    chk("R4 done", busy, 0);
    chk("R4 mem", mem[15'h5123], 8'h3C);

    // Expanded verify (R4)
    run(1'b0, 1'b1, 1'b0, 3'b010, 15'h5123, 8'h00, 9);
    chk("R4 xver read", mem_re, 1);
    nclk(1);
    chk("R4 xver data", rdata, 8'h3C);
    chk("R4 xver valid", rd_valid, 1);

    // Control write, then program must not remap (R7, R6)
    run(1'b0, 1'b0, 1'b1, 3'b011, 15'h0010, 8'h08, 2);
    chk("R7 ctrl write", ctrl, 8'h08);
    run(1'b0, 1'b0, 1'b1, 3'b100, 15'h0001, 8'h11, 2);
    chk("R6 no second map", ctrl, 8'h08);
    for (int k = 0; k < 5; k++)
      run(1'b0, 1'b0, 1'b1, 3'b011, 15'(8'h11 + k), 8'(8'hA0 + k), 2);
    chk("R7 keys", key, 40'hA4A3A2A1A0);
    chk("R7 no memory write", mem[15'h0011], seed(15'h0011));

    // Bad register address and undefined pins (R9)
    run(1'b0, 1'b0, 1'b1, 3'b011, 15'h0110, 8'h55, 1);
    chk("R9 bad hi addr err", mode_err, 1);
    chk("R9 bad hi addr idle", busy, 0);
    nclk(1);
    chk("R9 err one clock", mode_err, 0);
    run(1'b0, 1'b0, 1'b1, 3'b011, 15'h0016, 8'h55, 2);
    chk("R9 ctrl unchanged", ctrl, 8'h08);
    chk("R9 keys unchanged", key, 40'hA4A3A2A1A0);
    run(1'b0, 1'b0, 1'b1, 3'b000, 15'h0ABC, 8'h99, 1);
    chk("R9 verify select with strobe", mode_err, 1);
    nclk(1);
    chk("R9 mem kept", mem[15'h0ABC], 8'h5A);

    // Load reset low (R10)
    neutral(); nclk(1);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 3'b100, 15'h0ABC, 8'hEE);
    begin
      int w = 0;
      for (int i = 0; i < 5; i++) begin @(negedge clk); w += int'(mem_we) + int'(busy); end
      chk("R10 no cycle", w, 0);
    end
    chk("R10 mem kept", mem[15'h0ABC], 8'h5A);

    // Lock and locked verify (R5, R8)
    run(1'b0, 1'b0, 1'b1, 3'b111, 15'h0ABC, 8'h00, 2);
    chk("R5 lock set", ctrl, 8'h09);
    run(1'b1, 1'b1, 1'b0, 3'b001, 15'h0ABC, 8'h00, 2);
    chk("R8 locked verify", rdata, 8'hFF);
    run(1'b0, 1'b1, 1'b0, 3'b010, 15'h5123, 8'h00, 10);
    chk("R8 locked xverify", rdata, 8'hFF);
    run(1'b0, 1'b0, 1'b1, 3'b100, 15'h0002, 8'h22, 2);
    chk("R5 lock kept", ctrl[0], 1);
    run(1'b0, 1'b0, 1'b1, 3'b011, 15'h0010, 8'h08, 2);
    chk("R7 unlock", ctrl, 8'h08);
    run(1'b1, 1'b1, 1'b0, 3'b000, 15'h0ABC, 8'h00, 2);
    chk("R8 unlocked verify", rdata, 8'h5A);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule